// File: doc/BRIEF.md
# Conditional Trap Generator for Bounds and Overflow Checks

This block sits in an execution unit beside the instruction sequencer. When a range-check or an overflow-check instruction reaches execution, the sequencer presents one request. The request carries a kind select, the signed value under test, the two limit words already fetched from memory and the current overflow flag. The lower limit is the word at the operand address and the upper limit is the word two bytes above it. The block decides whether the instruction must raise an exception.

One clock after the request strobe, the block pulses a completion flag. In the same cycle it either raises a trap request with the interrupt type number to enter, or signals that the instruction retires as a no-operation so that execution continues with the next instruction. A range violation raises type 5 and an overflow trap raises type 4. Memory access for the limits and the interrupt entry sequence itself belong to neighbouring blocks. A request may be presented on every clock.

Top module: `boundsOvfTrap`

## Requirements
- R1: While `rstN` is low, and in the first cycle after it rises if no request was made, `outDone`, `outTrap`, `outNop` and `outType` are all 0.
- R2: Each cycle with `inValid`=1 yields exactly one `outDone`=1 in the following cycle; `outDone` is 0 in any cycle that does not follow a request, and back-to-back requests give back-to-back completions.
- R3: With `opSel`=0 (range check), a `testVal` below `lowLimit`, compared as signed 16-bit two's complement, gives `outTrap`=1 with `outType`=5.
- R4: With `opSel`=0, a `testVal` above `highLimit` (signed compare) gives `outTrap`=1 with `outType`=5.
- R5: With `opSel`=0, a `testVal` with lowLimit <= testVal <= highLimit (both ends inclusive, signed) gives `outTrap`=0 and `outNop`=1.
- R6: With `opSel`=1 (overflow check) and `ovFlag`=1, the result is `outTrap`=1 with `outType`=4.
- R7: With `opSel`=1 and `ovFlag`=0, the result is `outTrap`=0 and `outNop`=1.
- R8: `outType` is 0 in every cycle with `outTrap`=0, and `outNop` equals `outDone` and not `outTrap`.
- R9: `ovFlag` has no effect on a range check, and the limit inputs have no effect on an overflow check.
- R10: When `lowLimit` is greater than `highLimit` (signed), every range check traps with type 5.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Request strobe, one cycle per instruction |
| opSel | input | 1 | 0 = range check, 1 = overflow check |
| testVal | input | 16 | Signed value under test |
| lowLimit | input | 16 | Signed lower limit word (operand address) |
| highLimit | input | 16 | Signed upper limit word (operand address + 2) |
| ovFlag | input | 1 | Overflow flag of the current state |
| outDone | output | 1 | Completion pulse, one cycle after the request |
| outTrap | output | 1 | Trap request, valid with `outDone` |
| outType | output | 8 | Interrupt type number when `outTrap`=1, otherwise 0 |
| outNop | output | 1 | Instruction retires without a trap |

## Verification
The result of one request and the acceptance of the next fall in the same cycle whenever requests arrive on consecutive clocks. In that cycle the result registers must show the previous verdict while the next one is being captured. The bench provokes this with unbroken runs of requests that alternate kind and verdict, so a trap lands next to a no-operation and type 5 lands next to type 4. A queued expectation per request is matched against each completion in order, and a missing or extra `outDone` is judged as a failure as well as a wrong verdict or type.

// File: rtl/trapPkg.sv
package trapPkg;
  typedef enum logic {
    OP_BOUNDS   = 1'b0,
    OP_OVERFLOW = 1'b1
  } opKind_e;

  typedef struct packed {
    logic load;
    logic selBounds;
    logic selOverflow;
  } trapStrobes_t;
endpackage

// File: rtl/trapCtrl.sv
module trapCtrl
  import trapPkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         inValid,
  input  logic         opSel,
  output trapStrobes_t strobes,
  output logic         doneQ
);
  always_comb begin
    strobes             = '0;
    strobes.load        = inValid;
    strobes.selBounds   = inValid && (opKind_e'(opSel) == OP_BOUNDS);
    strobes.selOverflow = inValid && (opKind_e'(opSel) == OP_OVERFLOW);
  end

  always_ff @(posedge clk) begin
    if (!rstN) doneQ <= 1'b0;
    else       doneQ <= strobes.load;
  end
endmodule

// File: rtl/trapDatapath.sv
module trapDatapath
  import trapPkg::*;
#(
  parameter int unsigned DATA_W     = 16,
  parameter int unsigned TYPE_W     = 8,
  parameter int unsigned BOUND_TYPE = 5,
  parameter int unsigned OVF_TYPE   = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  trapStrobes_t      strobes,
  input  logic [DATA_W-1:0] testVal,
  input  logic [DATA_W-1:0] lowLimit,
  input  logic [DATA_W-1:0] highLimit,
  input  logic              ovFlag,
  output logic              trapQ,
  output logic [TYPE_W-1:0] typeQ
);
  localparam logic [TYPE_W-1:0] BOUND_CODE = TYPE_W'(BOUND_TYPE);
  localparam logic [TYPE_W-1:0] OVF_CODE   = TYPE_W'(OVF_TYPE);

  logic              belowLow;
  logic              aboveHigh;
  logic              boundsHit;
  logic              trapNext;
  logic [TYPE_W-1:0] typeNext;

  always_comb begin
    belowLow  = $signed(testVal) < $signed(lowLimit);
    aboveHigh = $signed(testVal) > $signed(highLimit);
    boundsHit = belowLow || aboveHigh;
    trapNext  = (strobes.selBounds && boundsHit) || (strobes.selOverflow && ovFlag);
    if (!trapNext)              typeNext = '0;
    else if (strobes.selBounds) typeNext = BOUND_CODE;
    else                        typeNext = OVF_CODE;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      trapQ <= 1'b0;
      typeQ <= '0;
    end else if (strobes.load) begin
      trapQ <= trapNext;
      typeQ <= typeNext;
    end else begin
      trapQ <= 1'b0;
      typeQ <= '0;
    end
  end
endmodule

// File: rtl/boundsOvfTrap.sv
module boundsOvfTrap
  import trapPkg::*;
#(
  parameter int unsigned DATA_W     = 16,
  parameter int unsigned TYPE_W     = 8,
  parameter int unsigned BOUND_TYPE = 5,
  parameter int unsigned OVF_TYPE   = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic              opSel,
  input  logic [DATA_W-1:0] testVal,
  input  logic [DATA_W-1:0] lowLimit,
  input  logic [DATA_W-1:0] highLimit,
  input  logic              ovFlag,
  output logic              outDone,
  output logic              outTrap,
  output logic [TYPE_W-1:0] outType,
  output logic              outNop
);
  trapStrobes_t strobes;
  logic         doneQ;
  logic         trapQ;

  trapCtrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .inValid (inValid),
    .opSel   (opSel),
    .strobes (strobes),
    .doneQ   (doneQ)
  );

  trapDatapath #(
    .DATA_W     (DATA_W),
    .TYPE_W     (TYPE_W),
    .BOUND_TYPE (BOUND_TYPE),
    .OVF_TYPE   (OVF_TYPE)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .testVal   (testVal),
    .lowLimit  (lowLimit),
    .highLimit (highLimit),
    .ovFlag    (ovFlag),
    .trapQ     (trapQ),
    .typeQ     (outType)
  );

  assign outDone = doneQ;
  assign outTrap = trapQ;
  assign outNop  = doneQ && !trapQ;
endmodule

// File: rtl/trapChecker.sv
module trapChecker #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned TYPE_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              inValid,
  input logic              opSel,
  input logic [DATA_W-1:0] testVal,
  input logic [DATA_W-1:0] lowLimit,
  input logic [DATA_W-1:0] highLimit,
  input logic              ovFlag,
  input logic              outDone,
  input logic              outTrap,
  input logic [TYPE_W-1:0] outType,
  input logic              outNop
);
  logic inRange;
  assign inRange = ($signed(testVal) >= $signed(lowLimit)) &&
                   ($signed(testVal) <= $signed(highLimit));

  AST_DONE_AFTER_REQ: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outDone);                                                   // R2
  AST_NO_STRAY_DONE: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outDone);                                                 // R2
  AST_BOUNDS_OUTSIDE: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !opSel && !inRange) |=> (outTrap && outType == TYPE_W'(5))); // R3
  AST_BOUNDS_INSIDE: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !opSel && inRange) |=> (outNop && !outTrap));               // R5
  AST_OVF_TRAP: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && opSel && ovFlag) |=> (outTrap && outType == TYPE_W'(4)));   // R6
  AST_OVF_NOP: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && opSel && !ovFlag) |=> (outNop && !outTrap));                // R7
  AST_TYPE_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !outTrap |-> (outType == '0));                                          // R8
  AST_TRAP_WITH_DONE: assert property (@(posedge clk) disable iff (!rstN)
    outTrap |-> (outDone && !outNop));                                      // R8
endmodule

bind boundsOvfTrap trapChecker #(.DATA_W(DATA_W), .TYPE_W(TYPE_W)) u_trapChecker (
  .clk       (clk),
  .rstN      (rstN),
  .inValid   (inValid),
  .opSel     (opSel),
  .testVal   (testVal),
  .lowLimit  (lowLimit),
  .highLimit (highLimit),
  .ovFlag    (ovFlag),
  .outDone   (outDone),
  .outTrap   (outTrap),
  .outType   (outType),
  .outNop    (outNop)
);

// File: tb/boundsOvfTrap_bench.sv
`timescale 1ns/1ps
module boundsOvfTrap_bench;
  logic        clk = 1'b0;
  logic        rstN;
  logic        inValid;
  logic        opSel;
  logic [15:0] testVal;
  logic [15:0] lowLimit;
  logic [15:0] highLimit;
  logic        ovFlag;
  logic        outDone;
  logic        outTrap;
  logic [7:0]  outType;
  logic        outNop;

  int checkCnt = 0;
  int failCnt  = 0;
  bit finished = 0;
  bit monOn    = 0;

  logic [8:0] expQ[$];
  string      tagQ[$];

  always #4 clk = ~clk;

  boundsOvfTrap u_boundsOvfTrap (
    .clk(clk), .rstN(rstN), .inValid(inValid), .opSel(opSel),
    .testVal(testVal), .lowLimit(lowLimit), .highLimit(highLimit),
    .ovFlag(ovFlag), .outDone(outDone), .outTrap(outTrap),
    .outType(outType), .outNop(outNop)
  );

  function automatic logic [8:0] model(input logic op, input logic [15:0] v,
                                       input logic [15:0] lo, input logic [15:0] hi,
                                       input logic of);
    int sv, slo, shi;
    sv  = int'($signed(v));
    slo = int'($signed(lo));
    shi = int'($signed(hi));
    if (!op) return (sv < slo || sv > shi) ? {1'b1, 8'd5} : 9'd0;
    return of ? {1'b1, 8'd4} : 9'd0;
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    checkCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic drive(input string tag, input logic op, input logic [15:0] v,
                       input logic [15:0] lo, input logic [15:0] hi, input logic of);
    @(negedge clk);
    inValid   = 1'b1;
    opSel     = op;
    testVal   = v;
    lowLimit  = lo;
    highLimit = hi;
    ovFlag    = of;
    expQ.push_back(model(op, v, lo, hi, of));
    tagQ.push_back(tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      inValid = 1'b0;
    end
  endtask

  task automatic finishRun;
    if (!finished) begin
      finished = 1;
      $display("  %0d/%0d checks passed", checkCnt - failCnt, checkCnt);
      $finish;
    end
  endtask

  // Monitor: samples 2 ns after each rising edge.
  always @(posedge clk) begin
    #2;
    if (monOn) begin
      if (expQ.size() != 0) begin
        logic [8:0] e;
        string      t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        check(outDone == 1'b1, t, "done", int'(outDone), 1);
        check(outTrap == e[8], t, "trap", int'(outTrap), int'(e[8]));
        check(outType == e[7:0], t, "type", int'(outType), int'(e[7:0]));
        check(outNop == !e[8], "R8", "nop", int'(outNop), int'(!e[8]));
      end else begin
        check(outDone == 1'b0, "R2", "idle done", int'(outDone), 0);
        check(outType == 8'd0, "R8", "idle type", int'(outType), 0);
      end
    end
  end

  initial begin
    #(200_000 * 8);
    check(1'b0, "WATCHDOG", "timeout", 0, 1);
    finishRun();
  end

  initial begin
    rstN = 1'b0; inValid = 1'b0; opSel = 1'b0; testVal = '0;
    lowLimit = '0; highLimit = '0; ovFlag = 1'b0;
    // Request held during reset must not produce a result (R1)
    repeat (3) @(negedge clk);
    inValid = 1'b1; opSel = 1'b1; ovFlag = 1'b1;
    @(negedge clk);
    check(outDone == 0 && outTrap == 0 && outType == 0 && outNop == 0,
          "R1", "reset outputs", int'({outDone, outTrap, outNop}), 0);
    inValid = 1'b0; ovFlag = 1'b0;
    rstN = 1'b1;
    @(negedge clk);
    check(outDone == 0 && outTrap == 0 && outType == 0 && outNop == 0,
          "R1", "post-reset outputs", int'({outDone, outTrap, outNop}), 0);
    monOn = 1;

    // Range checks, signed compares
    drive("R3", 1'b0, 16'sd9,     16'sd10,    16'sd20, 1'b0);
    drive("R4", 1'b0, 16'sd21,    16'sd10,    16'sd20, 1'b0);
    drive("R5", 1'b0, 16'sd10,    16'sd10,    16'sd20, 1'b0);
    drive("R5", 1'b0, 16'sd20,    16'sd10,    16'sd20, 1'b0);
    drive("R5", 1'b0, 16'sd15,    16'sd10,    16'sd20, 1'b0);
    idle(2);
    drive("R3", 1'b0, 16'hFFFB,   16'hFFFC,   16'sd3,  1'b0); // -5 < -4
    drive("R5", 1'b0, 16'hFFFC,   16'hFFFC,   16'sd3,  1'b0);
    drive("R4", 1'b0, 16'h0004,   16'hFFFC,   16'sd3,  1'b0);
    drive("R3", 1'b0, 16'h8000,   16'h8001,   16'h7FFF, 1'b0);
    drive("R5", 1'b0, 16'h7FFF,   16'h8000,   16'h7FFF, 1'b0);
    drive("R4", 1'b0, 16'h0000,   16'h8000,   16'hFFFF, 1'b0); // 0 > -1
    drive("R5", 1'b0, 16'sd7,     16'sd7,     16'sd7,   1'b0);
    idle(1);
    // Overflow checks
    drive("R6", 1'b1, 16'sd0,     16'sd0,     16'sd0,  1'b1);
    drive("R7", 1'b1, 16'sd0,     16'sd0,     16'sd0,  1'b0);
    drive("R6", 1'b1, 16'sd99,    16'sd0,     16'sd0,  1'b1);
    idle(3);
    // Ignored inputs
    drive("R9", 1'b0, 16'sd15,    16'sd10,    16'sd20, 1'b1); // flag ignored
    drive("R9", 1'b1, 16'sd500,   16'sd10,    16'sd20, 1'b0); // limits ignored
    drive("R9", 1'b1, 16'sd15,    16'sd10,    16'sd20, 1'b1);
    drive("R9", 1'b0, 16'sd5,     16'sd10,    16'sd20, 1'b1);
    idle(1);
    // Inverted limits
    drive("R10", 1'b0, 16'sd15,   16'sd20,    16'sd10, 1'b0);
    drive("R10", 1'b0, 16'sd10,   16'sd20,    16'sd10, 1'b0);
    drive("R10", 1'b0, 16'sd20,   16'sd20,    16'sd10, 1'b0);
    idle(2);
    // Back-to-back alternation (R2)
    for (int i = 0; i < 40; i++) begin
      if (i % 4 == 0)      drive("R2", 1'b0, 16'sd3,  16'sd0, 16'sd5, 1'b1);
      else if (i % 4 == 1) drive("R2", 1'b1, 16'sd3,  16'sd0, 16'sd5, 1'b1);
      else if (i % 4 == 2) drive("R2", 1'b0, 16'hFFFF, 16'sd0, 16'sd5, 1'b0);
      else                 drive("R2", 1'b1, 16'sd3,  16'sd0, 16'sd5, 1'b0);
    end
    idle(1);
    // Pseudo-random mix
    for (int i = 0; i < 300; i++) begin
      logic [15:0] a, b, c;
      a = 16'($urandom);
      b = 16'($urandom);
      c = 16'($urandom);
      drive(i[0] ? "R3" : "R4", 1'(($urandom) & 1), a, b, c, 1'(($urandom) & 1));
      if ((i % 7) == 0) idle(1);
    end
    idle(4);
    check(expQ.size() == 0, "R2", "pending results", expQ.size(), 0);
    finishRun();
  end
endmodule